// File: doc/BRIEF.md
# Binary64 Floating-Point Comparator

This block compares two IEEE-754 binary64 operands and reports their relation as a one-hot condition code. It also reports two invalid-operation status bits: one for a signalling NaN and one for an invalid compare. A single `start` strobe launches a compare. One clock later the block registers the condition code and both status bits, and it pulses `done` for one cycle. The registered results then hold until the next `start`.

Two compare flavours share the same datapath and are selected by `ordered`. The condition code is always computed, including when the operands are NaNs, and it is the same in both flavours. The flavours differ only in the invalid-compare bit. In the unordered flavour that bit never sets. In the ordered flavour it depends on which kind of NaN is present and on the invalid-operation enable input `inv_en`. Each compare replaces both status bits completely, so a flag never survives from one compare to the next.

The interface is a plain strobe pair and has no back-pressure, because each compare finishes in a fixed single cycle. A new `start` may be issued in every cycle, and each result is overwritten by the next one.

Top module: `fpcmp_unit`

## Requirements
- R1: If either operand is a NaN (exponent all ones, fraction nonzero), the condition code is unordered, `cc` = 4'b0001, in both flavours.
- R2: If either operand is a signalling NaN (NaN with fraction MSB, bit 51, equal to 0), `vxsnan` is 1 in both flavours; otherwise `vxsnan` is 0.
- R3: In the ordered flavour (`ordered`=1) with a signalling NaN present, `vxvc` equals the inverse of `inv_en`.
- R4: In the ordered flavour with no signalling NaN but at least one quiet NaN (fraction MSB 1), `vxvc` is 1 for either value of `inv_en`.
- R5: In the unordered flavour (`ordered`=0), `vxvc` is always 0.
- R6: Each compare recomputes both status bits from its own operands. A compare of two non-NaN operands leaves both bits 0, whatever the previous compare produced.
- R7: Positive and negative zero compare equal (`cc` = 4'b0010), and two infinities of the same sign compare equal.
- R8: Non-NaN operands are ordered by sign and magnitude. `cc` bit 3 means a<b, bit 2 means a>b and bit 1 means a=b. When both operands are negative, the magnitude order is reversed. Mixed signs decide by sign unless both operands are zero.
- R9: After every compare exactly one bit of `cc` is set.
- R10: `cc`, `vxsnan` and `vxvc` update on the clock edge that samples `start`=1, and `done` is 1 for exactly the following cycle. Without `start`, the outputs hold their values and `done` is 0.
- R11: After reset, `done`, `cc`, `vxsnan` and `vxvc` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a compare with the present inputs |
| ordered | input | 1 | 1 selects the ordered flavour, 0 the unordered flavour |
| inv_en | input | 1 | Invalid-operation exceptions enabled |
| op_a | input | 64 | First binary64 operand |
| op_b | input | 64 | Second binary64 operand |
| done | output | 1 | One-cycle pulse marking a fresh result |
| cc | output | 4 | Condition code {LT, GT, EQ, UN} |
| vxsnan | output | 1 | Signalling-NaN invalid flag |
| vxvc | output | 1 | Invalid-compare flag |

## Verification
Every result of this block is due exactly one rising edge after the edge that samples `start`. The bench drives `start` high on a falling edge and drops it on the next falling edge. It reads `done`, `cc` and both flags at that second falling edge, which is half a cycle after the registering edge. Hold behaviour is checked by sampling the same outputs on later falling edges while `start` stays low. Reset values are read on a falling edge before the first `start`.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  localparam int CC_W  = 4;
  localparam int CC_LT = 3;
  localparam int CC_GT = 2;
  localparam int CC_EQ = 1;
  localparam int CC_UN = 0;

  typedef struct packed {
    logic sign;
    logic is_zero;
    logic is_nan;
    logic is_snan;
    logic is_qnan;
  } fp_class_t;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] operand,
  output fp_class_t    cls,
  output logic [W-2:0] magnitude
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones;
  logic              frac_nz;

  assign exp_f     = operand[W-2 -: EXP_W];
  assign frac_f    = operand[FRAC_W-1:0];
  assign exp_ones  = &exp_f;
  assign frac_nz   = |frac_f;
  assign magnitude = operand[W-2:0];

  always_comb begin
    cls         = '0;
    cls.sign    = operand[W-1];
    cls.is_zero = (magnitude == '0);
    cls.is_nan  = exp_ones & frac_nz;
    cls.is_qnan = cls.is_nan &  frac_f[FRAC_W-1];
    cls.is_snan = cls.is_nan & ~frac_f[FRAC_W-1];
  end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
#(
  parameter int MAG_W = 63
) (
  input  fp_class_t        cls_a,
  input  fp_class_t        cls_b,
  input  logic [MAG_W-1:0] mag_a,
  input  logic [MAG_W-1:0] mag_b,
  output logic [CC_W-1:0]  cc_next
);
  logic unord;
  logic zeros;
  logic mag_less;
  logic mag_same;

  assign unord    = cls_a.is_nan | cls_b.is_nan;
  assign zeros    = cls_a.is_zero & cls_b.is_zero;
  assign mag_less = (mag_a < mag_b);
  assign mag_same = (mag_a == mag_b);

  always_comb begin
    cc_next = '0;
    if (unord)                        cc_next[CC_UN] = 1'b1;
    else if (zeros)                   cc_next[CC_EQ] = 1'b1;
    else if (cls_a.sign != cls_b.sign) begin
      if (cls_a.sign)                 cc_next[CC_LT] = 1'b1;
      else                            cc_next[CC_GT] = 1'b1;
    end
    else if (mag_same)                cc_next[CC_EQ] = 1'b1;
    else if (mag_less ^ cls_a.sign)   cc_next[CC_LT] = 1'b1;
    else                              cc_next[CC_GT] = 1'b1;
  end
endmodule

// File: rtl/fpcmp_flags.sv
module fpcmp_flags
  import fpcmp_pkg::*;
(
  input  fp_class_t cls_a,
  input  fp_class_t cls_b,
  input  logic      ordered,
  input  logic      inv_en,
  output logic      snan_next,
  output logic      vc_next
);
  logic any_snan;
  logic any_qnan;

  assign any_snan  = cls_a.is_snan | cls_b.is_snan;
  assign any_qnan  = cls_a.is_qnan | cls_b.is_qnan;
  assign snan_next = any_snan;

  always_comb begin
    vc_next = 1'b0;
    if (ordered) begin
      if (any_snan)      vc_next = ~inv_en;
      else if (any_qnan) vc_next = 1'b1;
    end
  end
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            ordered,
  input  logic            inv_en,
  input  logic [W-1:0]    op_a,
  input  logic [W-1:0]    op_b,
  output logic            done,
  output logic [CC_W-1:0] cc,
  output logic            vxsnan,
  output logic            vxvc
);
  logic [W-1:0]    ops [2];
  fp_class_t       cls [2];
  logic [W-2:0]    mag [2];
  logic [CC_W-1:0] cc_next;
  logic            snan_next;
  logic            vc_next;

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_cls (
      .operand   (ops[g]),
      .cls       (cls[g]),
      .magnitude (mag[g])
    );
  end

  fpcmp_order #(.MAG_W(W-1)) i_order (
    .cls_a   (cls[0]),
    .cls_b   (cls[1]),
    .mag_a   (mag[0]),
    .mag_b   (mag[1]),
    .cc_next (cc_next)
  );

  fpcmp_flags i_flags (
    .cls_a     (cls[0]),
    .cls_b     (cls[1]),
    .ordered   (ordered),
    .inv_en    (inv_en),
    .snan_next (snan_next),
    .vc_next   (vc_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      cc     <= '0;
      vxsnan <= 1'b0;
      vxvc   <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        cc     <= cc_next;
        vxsnan <= snan_next;
        vxvc   <= vc_next;
      end
    end
  end

  logic nan_in;
  logic snan_in;
  assign nan_in  = cls[0].is_nan  | cls[1].is_nan;
  assign snan_in = cls[0].is_snan | cls[1].is_snan;

  // R1
  nan_unordered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start) && $past(nan_in)) |-> (cc == 4'b0001));

  // R2
  snan_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start) |-> (vxsnan == $past(snan_in)));

  // R5
  unord_no_vxvc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start) && !$past(ordered)) |-> !vxvc);

  // R9
  cc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(cc) == 1));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done == $past(start));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(start) |-> ($stable(cc) && $stable(vxsnan) && $stable(vxvc)));
endmodule

// File: tb/test_fpcmp_unit.sv
module test_fpcmp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ordered = 1'b0;
  logic        inv_en = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        done;
  logic [3:0]  cc;
  logic        vxsnan;
  logic        vxvc;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fpcmp_unit i_fpcmp_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .ordered(ordered), .inv_en(inv_en),
    .op_a(op_a), .op_b(op_b), .done(done), .cc(cc), .vxsnan(vxsnan), .vxvc(vxvc)
  );

  localparam logic [63:0] P_ONE = 64'h3FF0000000000000;
  localparam logic [63:0] P_TWO = 64'h4000000000000000;
  localparam logic [63:0] N_ONE = 64'hBFF0000000000000;
  localparam logic [63:0] N_TWO = 64'hC000000000000000;
  localparam logic [63:0] P_ZER = 64'h0000000000000000;
  localparam logic [63:0] N_ZER = 64'h8000000000000000;
  localparam logic [63:0] P_INF = 64'h7FF0000000000000;
  localparam logic [63:0] N_INF = 64'hFFF0000000000000;
  localparam logic [63:0] QNAN  = 64'h7FF8000000000000;
  localparam logic [63:0] SNAN  = 64'h7FF0000000000001;

  // {a, b, ordered, inv_en, cc, vxsnan, vxvc}
  localparam int NV = 14;
  localparam logic [135:0] TBL [NV] = '{
    {P_ONE, P_TWO, 1'b0, 1'b0, 4'b1000, 1'b0, 1'b0},  // R8
    {P_TWO, P_ONE, 1'b1, 1'b0, 4'b0100, 1'b0, 1'b0},  // R8
    {N_ONE, N_TWO, 1'b0, 1'b0, 4'b0100, 1'b0, 1'b0},  // R8 negatives
    {N_TWO, N_ONE, 1'b1, 1'b1, 4'b1000, 1'b0, 1'b0},  // R8
    {P_ZER, N_ZER, 1'b1, 1'b0, 4'b0010, 1'b0, 1'b0},  // R7
    {N_ONE, P_ONE, 1'b0, 1'b0, 4'b1000, 1'b0, 1'b0},  // R8 mixed
    {QNAN,  P_ONE, 1'b1, 1'b1, 4'b0001, 1'b0, 1'b1},  // R4
    {QNAN,  P_ONE, 1'b0, 1'b0, 4'b0001, 1'b0, 1'b0},  // R5
    {SNAN,  QNAN,  1'b1, 1'b1, 4'b0001, 1'b1, 1'b0},  // R3
    {P_ONE, SNAN,  1'b1, 1'b0, 4'b0001, 1'b1, 1'b1},  // R3
    {SNAN,  P_ONE, 1'b0, 1'b0, 4'b0001, 1'b1, 1'b0},  // R2
    {P_INF, P_INF, 1'b1, 1'b0, 4'b0010, 1'b0, 1'b0},  // R7
    {N_INF, P_INF, 1'b0, 1'b0, 4'b1000, 1'b0, 1'b0},  // R8
    {N_INF, N_INF, 1'b0, 1'b1, 4'b0010, 1'b0, 1'b0}   // R7
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // launch one compare; returns at the falling edge after the result edge
  task automatic run(input logic [63:0] a, input logic [63:0] b, input logic ord, input logic ve);
    @(negedge clk);
    op_a = a; op_b = b; ordered = ord; inv_en = ve; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic logic is_nan(input logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
  endfunction

  // expected outcome from the requirements; ordering via real arithmetic
  function automatic logic [5:0] model(input logic [63:0] a, input logic [63:0] b,
                                       input logic ord, input logic ve);
    logic sn, qn;
    logic [3:0] c;
    logic vc;
    real ra, rb;
    sn = (is_nan(a) && !a[51]) || (is_nan(b) && !b[51]);
    qn = (is_nan(a) && a[51]) || (is_nan(b) && b[51]);
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    if (is_nan(a) || is_nan(b)) c = 4'b0001;
    else if (ra < rb)            c = 4'b1000;
    else if (ra > rb)            c = 4'b0100;
    else                         c = 4'b0010;
    if (!ord)    vc = 1'b0;
    else if (sn) vc = !ve;
    else         vc = qn;
    return {c, sn, vc};
  endfunction

  localparam int NS = 12;
  localparam logic [63:0] SPECIALS [NS] = '{
    P_ZER, N_ZER, P_INF, N_INF, QNAN, 64'hFFF8000000000123,
    SNAN, 64'hFFF4000000000000, P_ONE, N_ONE,
    64'h0000000000000001, 64'h7FEFFFFFFFFFFFFF
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [5:0] e;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 done", 64'(done), 64'd0);
    check("R11 cc", 64'(cc), 64'd0);
    check("R11 flags", 64'({vxsnan, vxvc}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle done", 64'(done), 64'd0);

    for (int i = 0; i < NV; i++) begin
      run(TBL[i][135:72], TBL[i][71:8], TBL[i][7], TBL[i][6]);
      check("R10 done", 64'(done), 64'd1);
      check("R1/R7/R8 cc", 64'(cc), 64'(TBL[i][5:2]));
      check("R2 vxsnan", 64'(vxsnan), 64'(TBL[i][1]));
      check("R3/R4/R5 vxvc", 64'(vxvc), 64'(TBL[i][0]));
    end

    // every special pair, both flavours, both enable values
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < NS; i++) begin
        for (int j = 0; j < NS; j++) begin
          run(SPECIALS[i], SPECIALS[j], m[1], m[0]);
          e = model(SPECIALS[i], SPECIALS[j], m[1], m[0]);
          check("R1/R7/R8 sweep cc", 64'(cc), 64'(e[5:2]));
          check("R9 onehot", 64'($countones(cc)), 64'd1);
          check("R2 sweep vxsnan", 64'(vxsnan), 64'(e[1]));
          check("R3/R4/R5 sweep vxvc", 64'(vxvc), 64'(e[0]));
        end
      end
    end

    // R6: flags from a NaN compare do not carry into a normal compare
    run(SNAN, QNAN, 1'b1, 1'b0);
    check("R6 setup", 64'({vxsnan, vxvc}), 64'b11);
    run(P_ONE, P_ONE, 1'b1, 1'b0);
    check("R6 cleared", 64'({vxsnan, vxvc}), 64'b00);
    check("R6 cc", 64'(cc), 64'b0010);

    // R10: hold with no start, and single-cycle done
    run(N_ONE, P_TWO, 1'b1, 1'b0);
    @(negedge clk);
    check("R10 done width", 64'(done), 64'd0);
    op_a = QNAN; op_b = SNAN; ordered = 1'b1; inv_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 hold cc", 64'(cc), 64'b1000);
    check("R10 hold flags", 64'({vxsnan, vxvc}), 64'b00);

    // R10: back-to-back starts
    @(negedge clk);
    op_a = P_TWO; op_b = P_ONE; ordered = 1'b0; start = 1'b1;
    @(negedge clk);
    check("R10 b2b first", 64'(cc), 64'b0100);
    op_a = P_ONE; op_b = P_TWO;
    @(negedge clk);
    start = 1'b0;
    check("R10 b2b second", 64'(cc), 64'b1000);
    check("R10 b2b done", 64'(done), 64'd1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule